// File: doc/BRIEF.md
# Processor Bus Request and Lock Handshake

This block sits between a processor core and an external shared-bus arbiter. The core reports that a bus cycle is waiting, whether that cycle is part of an atomic read-modify-write sequence, and whether it is the final cycle of such a sequence. The block raises an active-low request toward the arbiter one clock ahead of need. When the arbiter answers with an active-low grant, the block emits a one-clock start pulse to the bus cycle sequencer. The sequencer reports the end of each bus cycle with a done pulse.

The block keeps track of whether the current bus cycle belongs to this processor. It drives an active-low lock line for the whole of an atomic sequence, such as decrement-in-memory or test-and-set-bit. On bus cycles owned by another master, the lock line is released to high impedance. The high-impedance state is modelled with an explicit output enable. While the enable is low, the lock level is parked high. The lock is advisory only, so a lock line asserted by another master has no effect on when this block starts a cycle.

All outputs are registered. Reset is synchronous and active high.

Top module: `cpu_bus_arb_if`

## Requirements
- R1: In the clock after `rst` is sampled high, `req_n_o`=1, `lock_n_o`=1, `lock_oe_o`=0 and `start_o`=0. This holds even if a locked sequence was in progress.
- R2: Outside a start cycle and with no start taking place, `req_n_o` in the next clock equals the inverse of `cyc_pend_i`.
- R3: `start_o` is 1 for exactly one clock. That clock directly follows an edge at which `req_n_o`=0, `grant_n_i`=0 and `cyc_pend_i`=1, and at which the bus was free. The bus is free when no own cycle is active, or when the active one signals `cyc_done_i`=1 at that edge.
- R4: `start_o` stays 0 in the clock after any edge at which `cyc_pend_i`=0 or `grant_n_i`=1.
- R5: In a start clock for an unlocked cycle, or for the final cycle of a locked sequence, `req_n_o`=1. The core inputs are not looked at during a start clock, so `req_n_o` is still 1 in the following clock.
- R6: When the starting cycle has `cyc_locked_i`=1 and `cyc_last_i`=0, `req_n_o` stays 0 through its start clock and the whole gap up to the start of the next cycle.
- R7: `lock_n_o` is 0 from the start clock of the first locked cycle until the edge on which the final locked cycle reports `cyc_done_i`. This holds while the block owns the bus. `lock_n_o` is 1 in the clock after that edge.
- R8: During an own unlocked bus cycle, `lock_oe_o`=1 and `lock_n_o`=1.
- R9: The block treats a clock as foreign when it has no active own cycle and is not holding a granted locked sequence. In a foreign clock, `lock_oe_o`=0 and `lock_n_o` is parked at 1. This includes a gap inside a locked sequence when `grant_n_i` is 1.
- R10: The level on `bus_lock_n_i` has no effect on `start_o`, `req_n_o` or the lock outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_pend_i | input | 1 | Core has a bus cycle waiting |
| cyc_locked_i | input | 1 | Waiting cycle belongs to an atomic sequence |
| cyc_last_i | input | 1 | Waiting locked cycle is the final one of its sequence |
| cyc_done_i | input | 1 | Sequencer: current own bus cycle ends at this edge |
| grant_n_i | input | 1 | Arbiter grant, active low |
| bus_lock_n_i | input | 1 | Lock line as seen on the bus (advisory, ignored) |
| req_n_o | output | 1 | Bus request, active low |
| lock_n_o | output | 1 | Bus lock level, active low, parked high when not enabled |
| lock_oe_o | output | 1 | Output enable for the lock line |
| start_o | output | 1 | One-clock pulse: own bus cycle begins |

## Verification
The assertions assume a particular contract from the core and the sequencer. The core holds `cyc_pend_i` and its qualifiers steady until it sees `start_o`. It updates them during the start clock to describe the next cycle. It never begins an unlocked cycle in the middle of a locked sequence. The sequencer pulses `cyc_done_i` only while an own cycle is active. The stimulus keeps to this contract by generating `cyc_done_i` from a known cycle length counted from each observed start. It changes the core inputs only in the start clock or in idle clocks. The bench sweeps every combination of pend, grant and foreign lock from idle. It also runs locked sequences over several cycle lengths, once with the grant held through the gap and once with it withdrawn.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Description of the bus cycle the core wants next.
  typedef struct packed {
    logic pend;    // a cycle is waiting
    logic locked;  // cycle is part of an atomic sequence
    logic last;    // final cycle of that sequence
  } core_req_t;

  // Whether a locked cycle keeps the bus for a follower.
  function automatic logic keeps_bus(input core_req_t r);
    return r.locked && !r.last;
  endfunction

endpackage

// File: rtl/arb_req_ctl.sv
module arb_req_ctl
  import arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  core_req_t creq_i,
  input  logic      grant_n_i,
  input  logic      cyc_done_i,
  input  logic      bus_lock_n_i,
  output logic      req_n_o,
  output logic      start_o,
  output logic      start_nx_o,
  output logic      busy_o,
  output logic      busy_nx_o
);

  logic busy_q;
  logic bus_free;
  logic req_n_nx;

  // The bus is free for a new own cycle when nothing of ours is active,
  // or when our active cycle ends at this very edge.
  assign bus_free = !busy_q || cyc_done_i;

  // Core inputs are disregarded during a start clock.
  assign start_nx_o = !req_n_o && !grant_n_i && creq_i.pend && !start_o && bus_free;

  assign busy_nx_o = start_nx_o || (busy_q && !cyc_done_i);

  always_comb begin
    if (start_nx_o) begin
      req_n_nx = !keeps_bus(creq_i);
    end else if (start_o) begin
      req_n_nx = req_n_o;
    end else begin
      req_n_nx = !creq_i.pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_n_o <= 1'b1;
      start_o <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      req_n_o <= req_n_nx;
      start_o <= start_nx_o;
      busy_q  <= busy_nx_o;
    end
  end

  assign busy_o = busy_q;

  // R3: a start is always preceded by a request, a grant and a pending cycle
  assert_start_qualified_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(!req_n_o && !grant_n_i && creq_i.pend));

  // R3: the start pulse lasts one clock
  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R4: no pending cycle or no grant means no start
  assert_idle_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    (!creq_i.pend || grant_n_i) |=> !start_o);

  // R5: request released when the started cycle does not hold the bus
  assert_req_released_R5: assert property (@(posedge clk) disable iff (rst)
    (start_o && !$past(keeps_bus(creq_i))) |-> req_n_o);

  // R6: request kept low across a locked hand-over
  assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
    (start_o && $past(keeps_bus(creq_i))) |-> !req_n_o);

  // R10: a foreign lock does not block a granted start
  assert_foreign_lock_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_lock_n_i && !req_n_o && !grant_n_i && creq_i.pend && !start_o && bus_free)
      |=> start_o);

endmodule

// File: rtl/arb_lock_ctl.sv
module arb_lock_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start_nx_i,
  input  logic busy_i,
  input  logic busy_nx_i,
  input  logic locked_i,
  input  logic last_i,
  input  logic cyc_done_i,
  input  logic grant_n_i,
  output logic lock_n_o,
  output logic lock_oe_o
);

  logic seq_q, seq_nx;
  logic last_q, last_nx;
  logic oe_nx;

  always_comb begin
    seq_nx = seq_q;
    if (cyc_done_i && busy_i && last_q) begin
      seq_nx = 1'b0;
    end
    if (start_nx_i) begin
      seq_nx = locked_i;
    end
  end

  assign last_nx = start_nx_i ? (locked_i && last_i) : last_q;

  // Ownership: an active own cycle, or a locked sequence still granted.
  assign oe_nx = busy_nx_i || (seq_nx && !grant_n_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= 1'b0;
      last_q    <= 1'b0;
      lock_oe_o <= 1'b0;
      lock_n_o  <= 1'b1;
    end else begin
      seq_q     <= seq_nx;
      last_q    <= last_nx;
      lock_oe_o <= oe_nx;
      lock_n_o  <= !(seq_nx && oe_nx);
    end
  end

  // R9: lock level parked high when not driving
  assert_parked_high_R9: assert property (@(posedge clk) disable iff (rst)
    !lock_oe_o |-> lock_n_o);

  // R7: a locked start pulls the lock low in the start clock
  assert_lock_on_locked_start_R7: assert property (@(posedge clk) disable iff (rst)
    (start_nx_i && locked_i) |=> (!lock_n_o && lock_oe_o));

  // R7: lock released after the final locked cycle ends with nothing new
  assert_lock_release_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc_done_i && busy_i && last_q && !start_nx_i) |=> lock_n_o);

endmodule

// File: rtl/cpu_bus_arb_if.sv
module cpu_bus_arb_if
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_pend_i,
  input  logic cyc_locked_i,
  input  logic cyc_last_i,
  input  logic cyc_done_i,
  input  logic grant_n_i,
  input  logic bus_lock_n_i,
  output logic req_n_o,
  output logic lock_n_o,
  output logic lock_oe_o,
  output logic start_o
);

  core_req_t creq;
  logic      start_nx;
  logic      busy;
  logic      busy_nx;

  assign creq.pend   = cyc_pend_i;
  assign creq.locked = cyc_locked_i;
  assign creq.last   = cyc_last_i;

  arb_req_ctl u_req (
    .clk          (clk),
    .rst          (rst),
    .creq_i       (creq),
    .grant_n_i    (grant_n_i),
    .cyc_done_i   (cyc_done_i),
    .bus_lock_n_i (bus_lock_n_i),
    .req_n_o      (req_n_o),
    .start_o      (start_o),
    .start_nx_o   (start_nx),
    .busy_o       (busy),
    .busy_nx_o    (busy_nx)
  );

  arb_lock_ctl u_lock (
    .clk        (clk),
    .rst        (rst),
    .start_nx_i (start_nx),
    .busy_i     (busy),
    .busy_nx_i  (busy_nx),
    .locked_i   (cyc_locked_i),
    .last_i     (cyc_last_i),
    .cyc_done_i (cyc_done_i),
    .grant_n_i  (grant_n_i),
    .lock_n_o   (lock_n_o),
    .lock_oe_o  (lock_oe_o)
  );

  // R8: every own cycle drives the lock line in its start clock
  assert_own_cycle_driven_R8: assert property (@(posedge clk) disable iff (rst)
    start_o |-> lock_oe_o);

  // R8: an unlocked start leaves the lock released
  assert_unlocked_start_high_R8: assert property (@(posedge clk) disable iff (rst)
    (start_o && !$past(cyc_locked_i)) |-> lock_n_o);

endmodule

// File: tb/cpu_bus_arb_if_test.sv
`timescale 1ns/1ps
module cpu_bus_arb_if_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pend = 1'b0, locked = 1'b0, last = 1'b0, done = 1'b0;
  logic grant_n = 1'b1, flock_n = 1'b1;
  logic req_n, lock_n, lock_oe, start;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cpu_bus_arb_if uut (
    .clk          (clk),
    .rst          (rst),
    .cyc_pend_i   (pend),
    .cyc_locked_i (locked),
    .cyc_last_i   (last),
    .cyc_done_i   (done),
    .grant_n_i    (grant_n),
    .bus_lock_n_i (flock_n),
    .req_n_o      (req_n),
    .lock_n_o     (lock_n),
    .lock_oe_o    (lock_oe),
    .start_o      (start)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    pend = 0; locked = 0; last = 0; done = 0; grant_n = 1; flock_n = 1;
  endtask

  // Locked two-cycle sequence; each bus cycle lasts len clocks.
  task automatic locked_seq(input int len, input bit hold);
    bit second_started;
    pend = 1; locked = 1; last = 0; grant_n = 0; flock_n = hold ? 1'b0 : 1'b1;
    tick();
    chk("R2", "req_n", req_n, 1'b0);
    chk("R9", "lock_oe before start", lock_oe, 1'b0);
    tick();
    chk("R3", "start first", start, 1'b1);
    chk("R6", "req_n in locked start", req_n, 1'b0);
    chk("R7", "lock_n first", lock_n, 1'b0);
    chk("R8", "lock_oe own", lock_oe, 1'b1);
    last = 1;
    grant_n = hold ? 1'b0 : 1'b1;
    second_started = 0;
    for (int k = 0; k < len; k++) begin
      done = (k == len - 1);
      tick();
      if (k < len - 1) begin
        chk("R7", "lock_n mid first", lock_n, 1'b0);
        chk("R6", "req_n mid first", req_n, 1'b0);
        chk("R3", "no start mid", start, 1'b0);
      end else if (hold && len > 1) begin
        chk("R3", "back-to-back start", start, 1'b1);
        chk("R5", "req_n after last start", req_n, 1'b1);
        chk("R7", "lock_n continuous", lock_n, 1'b0);
        second_started = 1;
      end else begin
        chk("R3", "no start in gap", start, 1'b0);
        chk("R6", "req_n held in gap", req_n, 1'b0);
        chk("R9", "lock_oe in gap", lock_oe, hold);
        chk(hold ? "R7" : "R9", "lock_n in gap", lock_n, hold ? 1'b0 : 1'b1);
      end
    end
    done = 0;
    if (!second_started) begin
      grant_n = 0;
      tick();
      chk("R3", "second start", start, 1'b1);
      chk("R5", "req_n after last start", req_n, 1'b1);
      chk("R7", "lock_n second", lock_n, 1'b0);
      chk("R8", "lock_oe second", lock_oe, 1'b1);
    end
    pend = 0; locked = 0; last = 0;
    for (int k = 0; k < len; k++) begin
      done = (k == len - 1);
      tick();
      if (k < len - 1) begin
        chk("R7", "lock_n mid second", lock_n, 1'b0);
        chk("R8", "lock_oe mid second", lock_oe, 1'b1);
      end else begin
        chk("R7", "lock released", lock_n, 1'b1);
        chk("R9", "lock_oe after seq", lock_oe, 1'b0);
        chk("R3", "no extra start", start, 1'b0);
      end
    end
    go_idle();
    tick();
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    go_idle();
    rst = 1;
    tick();
    tick();
    chk("R1", "req_n", req_n, 1'b1);
    chk("R1", "lock_n", lock_n, 1'b1);
    chk("R1", "lock_oe", lock_oe, 1'b0);
    chk("R1", "start", start, 1'b0);
    rst = 0;
    tick();

    // Sweep pend / grant / foreign lock from idle, one-clock bus cycles.
    for (int c = 0; c < 8; c++) begin
      bit exp_start;
      pend = c[0]; grant_n = c[1]; flock_n = c[2];
      exp_start = c[0] && !c[1];
      tick();
      chk("R2", "req_n follows pend", req_n, !c[0]);
      chk("R4", "no start yet", start, 1'b0);
      tick();
      chk(exp_start ? "R3" : "R4", "start after grant", start, exp_start);
      chk("R10", "req_n with foreign lock", req_n, exp_start ? 1'b1 : !c[0]);
      if (exp_start) begin
        chk("R8", "lock_oe own unlocked", lock_oe, 1'b1);
        chk("R8", "lock_n own unlocked", lock_n, 1'b1);
      end else begin
        chk("R9", "lock_oe idle", lock_oe, 1'b0);
      end
      pend = 0; grant_n = 1; flock_n = 1; done = exp_start;
      tick();
      done = 0;
      chk("R3", "single pulse", start, 1'b0);
      chk("R9", "lock_oe foreign", lock_oe, 1'b0);
      chk("R9", "lock_n parked", lock_n, 1'b1);
      tick();
    end

    // Pending held through the start clock is not looked at.
    pend = 1; grant_n = 0;
    tick();
    tick();
    chk("R3", "start held-pend", start, 1'b1);
    done = 1;
    tick();
    done = 0;
    pend = 0; grant_n = 1;
    chk("R5", "req_n ignores pend in start clock", req_n, 1'b1);
    chk("R3", "no restart", start, 1'b0);
    tick();
    tick();

    for (int len = 1; len <= 3; len++) begin
      locked_seq(len, 1'b0);
      locked_seq(len, 1'b1);
    end

    // Reset in the middle of a locked sequence.
    pend = 1; locked = 1; last = 0; grant_n = 0;
    tick();
    tick();
    chk("R7", "lock low before reset", lock_n, 1'b0);
    rst = 1;
    tick();
    chk("R1", "req_n after reset", req_n, 1'b1);
    chk("R1", "lock_n after reset", lock_n, 1'b1);
    chk("R1", "lock_oe after reset", lock_oe, 1'b0);
    chk("R1", "start after reset", start, 1'b0);
    go_idle();
    tick();
    rst = 0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule